// File: doc/BRIEF.md
# SPI EEPROM Boot-Read Master

This block fetches configuration from a serial EEPROM by itself, with no outside command, each time reset is released. It drives the serial clock, which it derives from the fast system clock, and an active-low chip select. It sends the standard read command, then an all-zero start address. After that it keeps chip select low and clocks in as many bytes as the latched byte count asks for. Each received byte goes out on a strobe-qualified data port together with its position in the stream. When the last byte is in, chip select is released and a sticky done flag is raised.

A static phase-select pin chooses the clock shape. With phase select low, the clock idles low in the first half of each bit period and rises in the middle, so the master samples on the rising edge. With phase select high, the clock rises at the start of each bit period and falls in the middle, so the master samples on the falling edge. In both shapes the master changes its output at the start of a bit period and samples its input at the middle of the period. There is one boot read per reset. The byte count is clamped to the size of the memory.

Top module: `spi_boot_reader`

## Requirements
- R1: While reset is low, spi_cs_n is 1, and spi_sck, spi_mosi, rx_valid and boot_done are 0.
- R2: On the first clock edge after reset is released, byte_count is latched and spi_cs_n goes low. Later changes of byte_count have no effect on that read.
- R3: A bit period lasts CLK_DIV system cycles. Counting cycles p = 0..CLK_DIV-1 from the start of a period, spi_sck is high for p >= CLK_DIV/2 when cpha_sel = 0, and high for p < CLK_DIV/2 when cpha_sel = 1. spi_sck is 0 whenever spi_cs_n is 1.
- R4: spi_mosi carries 24 header bits, MSB first, one per bit period: the read command 0x03 followed by the 16-bit address 0x0000. It is 0 during every data bit period.
- R5: Data bits are sampled from spi_miso on the mid-period edge, which is the rising SCK edge when cpha_sel = 0 and the falling edge when cpha_sel = 1. The first bit received is the MSB of each byte.
- R6: Each received byte is presented through a one-cycle rx_valid pulse in the cycle after its eighth sampling edge, with rx_data and with rx_index counting 0, 1, 2, and so on.
- R7: spi_cs_n stays low until the last data bit period ends, and then goes high together with boot_done. boot_done then stays 1 until reset, and no further rx_valid occurs.
- R8: A byte_count above MAX_BYTES reads exactly MAX_BYTES bytes. A byte_count of 0 never lowers spi_cs_n and raises boot_done on the first edge after reset.
- R9: A reset during a read aborts it at once, and the next release starts a complete new read from index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts the read |
| cpha_sel | input | 1 | Clock shape select, held static during a read |
| byte_count | input | CNT_W | Number of bytes to read, latched at start |
| spi_miso | input | 1 | Serial data from the memory |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the memory |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| rx_index | output | IDX_W | Position of the byte in the stream |
| boot_done | output | 1 | Read complete, sticky until reset |

## Verification
Two events share an edge. The edge that closes the last bit period drops SCK (phase select low) and also raises chip select and done. The edge that opens the read lowers chip select and, with phase select high, also raises SCK. Both phase settings are run to completion, and a per-cycle reference model compares every output on every cycle. This shows that each coincident pair lands in the same cycle, with no extra SCK edge before or after. A byte count written just after the latching edge, and a reset asserted in the middle of a read, check that the latch and the restart do not disturb these boundaries.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_DONE = 2'd2
   } seq_state_t;

   localparam logic [7:0] READ_CMD = 8'h03;

endpackage

// File: rtl/spi_boot_sckgen.sv
module spi_boot_sckgen #(
   parameter int CLK_DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic stop,
   input  logic cpha,
   output logic sck,
   output logic mid_tick,
   output logic end_tick
);
   localparam int HALF = CLK_DIV / 2;
   localparam int PH_W = $clog2(CLK_DIV);

   logic [PH_W-1:0] ph_q, ph_nx;
   logic            running_q;

   assign ph_nx    = (ph_q == PH_W'(CLK_DIV - 1)) ? '0 : ph_q + 1'b1;
   assign mid_tick = running_q && (ph_q == PH_W'(HALF - 1));
   assign end_tick = running_q && (ph_q == PH_W'(CLK_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q      <= '0;
         running_q <= 1'b0;
         sck       <= 1'b0;
      end else if (start) begin
         ph_q      <= '0;
         running_q <= 1'b1;
         sck       <= cpha;
      end else if (stop) begin
         ph_q      <= '0;
         running_q <= 1'b0;
         sck       <= 1'b0;
      end else if (running_q) begin
         ph_q <= ph_nx;
         sck  <= cpha ? (ph_nx < PH_W'(HALF)) : (ph_nx >= PH_W'(HALF));
      end
   end

   // R3: a new period opens with the level chosen by the phase select
   p_period_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (end_tick && !stop) |=> (sck == $past(cpha)));

   // R5: the sampling edge toggles the clock to the opposite level
   p_mid_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mid_tick |=> (sck == !$past(cpha)));

endmodule

// File: rtl/spi_boot_txshift.sv
module spi_boot_txshift #(
   parameter int          HDR_BITS = 24,
   parameter logic [HDR_BITS-1:0] HEADER = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic shift,
   output logic mosi
);
   logic [HDR_BITS-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_q <= '0;
      else if (load)
         sh_q <= HEADER;
      else if (shift)
         sh_q <= {sh_q[HDR_BITS-2:0], 1'b0};
   end

   assign mosi = sh_q[HDR_BITS-1];

endmodule

// File: rtl/spi_boot_rxshift.sv
module spi_boot_rxshift #(
   parameter int IDX_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             miso,
   output logic             rx_valid,
   output logic [7:0]       rx_data,
   output logic [IDX_W-1:0] rx_index
);
   logic [6:0]       sh_q;
   logic [2:0]       cnt_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q     <= '0;
         cnt_q    <= '0;
         idx_q    <= '0;
         rx_valid <= 1'b0;
         rx_data  <= '0;
         rx_index <= '0;
      end else begin
         rx_valid <= 1'b0;
         if (take) begin
            sh_q  <= {sh_q[5:0], miso};
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
               rx_valid <= 1'b1;
               rx_data  <= {sh_q, miso};
               rx_index <= idx_q;
               idx_q    <= idx_q + 1'b1;
            end
         end
      end
   end

   // R6: a byte strobe lasts exactly one cycle
   p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

endmodule

// File: rtl/spi_boot_reader.sv
module spi_boot_reader #(
   parameter int CLK_DIV   = 12,
   parameter int MAX_BYTES = 2048,
   parameter int ADDR_W    = 16,
   localparam int CNT_W    = $clog2(MAX_BYTES + 1),
   localparam int IDX_W    = $clog2(MAX_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpha_sel,
   input  logic [CNT_W-1:0] byte_count,
   input  logic             spi_miso,
   output logic             spi_sck,
   output logic             spi_cs_n,
   output logic             spi_mosi,
   output logic             rx_valid,
   output logic [7:0]       rx_data,
   output logic [IDX_W-1:0] rx_index,
   output logic             boot_done
);
   import spi_boot_pkg::*;

   localparam int HDR_BITS = 8 + ADDR_W;
   localparam int BIT_W    = $clog2(HDR_BITS + 8 * MAX_BYTES + 1);
   localparam logic [HDR_BITS-1:0] HEADER = {READ_CMD, {ADDR_W{1'b0}}};

   generate
      if (CLK_DIV < 4 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 4");
      end
      if (MAX_BYTES < 2) begin : g_bad_max
         $error("MAX_BYTES must be at least 2");
      end
      if (ADDR_W < 8 || (ADDR_W % 8) != 0) begin : g_bad_addr
         $error("ADDR_W must be a multiple of 8");
      end
   endgenerate

   seq_state_t       state_q;
   logic [CNT_W-1:0] n_q, n_cl;
   logic [BIT_W-1:0] bit_q, last_q;
   logic             start, stop, mid_tick, end_tick, take;

   assign n_cl  = (byte_count > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : byte_count;
   assign start = (state_q == SEQ_IDLE) && (n_cl != '0);
   assign stop  = (state_q == SEQ_RUN) && end_tick && (bit_q == last_q);
   assign take  = (state_q == SEQ_RUN) && mid_tick && (bit_q >= BIT_W'(HDR_BITS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         n_q       <= '0;
         bit_q     <= '0;
         last_q    <= '0;
         spi_cs_n  <= 1'b1;
         boot_done <= 1'b0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               n_q    <= n_cl;
               bit_q  <= '0;
               last_q <= BIT_W'(HDR_BITS) + (BIT_W'(n_cl) << 3) - 1'b1;
               if (n_cl == '0) begin
                  state_q   <= SEQ_DONE;
                  boot_done <= 1'b1;
               end else begin
                  state_q  <= SEQ_RUN;
                  spi_cs_n <= 1'b0;
               end
            end
            SEQ_RUN: begin
               if (stop) begin
                  state_q   <= SEQ_DONE;
                  spi_cs_n  <= 1'b1;
                  boot_done <= 1'b1;
               end else if (end_tick) begin
                  bit_q <= bit_q + 1'b1;
               end
            end
            default: begin
               state_q <= SEQ_DONE;
            end
         endcase
      end
   end

   spi_boot_sckgen #(.CLK_DIV(CLK_DIV)) u_sckgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .stop     (stop),
      .cpha     (cpha_sel),
      .sck      (spi_sck),
      .mid_tick (mid_tick),
      .end_tick (end_tick)
   );

   spi_boot_txshift #(.HDR_BITS(HDR_BITS), .HEADER(HEADER)) u_txshift (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .shift (end_tick),
      .mosi  (spi_mosi)
   );

   spi_boot_rxshift #(.IDX_W(IDX_W)) u_rxshift (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .miso     (spi_miso),
      .rx_valid (rx_valid),
      .rx_data  (rx_data),
      .rx_index (rx_index)
   );

   // R7: done never drops before reset
   p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done |=> boot_done);

   // R7: chip select only rises together with done
   p_cs_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> boot_done);

   // R6: byte strobes only while the memory is selected
   p_valid_selected_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !spi_cs_n);

   // R3: no clock activity while deselected
   p_idle_sck_r3: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);

   // R4: output line is quiet during the data phase
   p_data_mosi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_RUN && bit_q >= BIT_W'(HDR_BITS)) |-> !spi_mosi);

   // R8: the byte index stays below the clamped count
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (CNT_W'(rx_index) < n_q));

endmodule

// File: tb/spi_boot_reader_bench.sv
module spi_boot_reader_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 12;
   localparam int MAXB       = 6;
   localparam int H          = DIV / 2;
   localparam int CNT_W      = $clog2(MAXB + 1);
   localparam int IDX_W      = $clog2(MAXB);
   localparam logic [23:0] HDR = 24'h030000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cpha_sel = 1'b0;
   logic [CNT_W-1:0] byte_count = '0;
   logic             spi_miso = 1'b0;
   logic             spi_sck, spi_cs_n, spi_mosi, rx_valid, boot_done;
   logic [7:0]       rx_data;
   logic [IDX_W-1:0] rx_index;

   int  vectors = 0;
   int  miscompares = 0;
   bit  finished = 0;
   int  seed = 0;
   int  n_lat = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   spi_boot_reader #(.CLK_DIV(DIV), .MAX_BYTES(MAXB)) u_spi_boot_reader (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpha_sel   (cpha_sel),
      .byte_count (byte_count),
      .spi_miso   (spi_miso),
      .spi_sck    (spi_sck),
      .spi_cs_n   (spi_cs_n),
      .spi_mosi   (spi_mosi),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .rx_index   (rx_index),
      .boot_done  (boot_done)
   );

   function automatic logic [7:0] mem_byte(input int i);
      return 8'((i * 53 + 29 + seed * 71) ^ (seed << 4));
   endfunction

   task automatic chk(input string req, input string tag, input string what,
                      input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         if (miscompares <= 30)
            $display("FAIL %s [%s] %s actual=%0d expected=%0d at %0t",
                     req, tag, what, act, exp, $time);
      end
   endtask

   // Reference model of one cycle after edge e (edges counted from release)
   task automatic model_cycle(input int e, input bit cp, input string tag);
      int  tot, t, b, p;
      bit  e_cs, e_sck, e_mosi, e_val, e_done;
      int  e_dat, e_idx;
      e_cs = 1; e_sck = 0; e_mosi = 0; e_val = 0; e_done = 0; e_dat = 0; e_idx = 0;
      b = -1;
      if (n_lat == 0) begin
         e_done = 1;
      end else begin
         tot = 24 + 8 * n_lat;
         if (e <= tot * DIV) begin
            t = e - 1; b = t / DIV; p = t % DIV;
            e_cs  = 0;
            e_sck = cp ? (p < H) : (p >= H);
            e_mosi = (b < 24) ? HDR[23 - b] : 1'b0;
            if (b >= 24 && p == H && ((b - 24) % 8) == 7) begin
               e_val = 1;
               e_idx = (b - 24) / 8;
               e_dat = int'(mem_byte(e_idx));
            end
         end else begin
            e_done = 1;
         end
      end
      chk((n_lat == 0) ? "R8" : ((e == 1) ? "R2" : "R7"), tag, "spi_cs_n", int'(spi_cs_n), int'(e_cs));
      chk("R3", tag, "spi_sck", int'(spi_sck), int'(e_sck));
      chk("R4", tag, "spi_mosi", int'(spi_mosi), int'(e_mosi));
      chk("R6", tag, "rx_valid", int'(rx_valid), int'(e_val));
      chk((n_lat == 0) ? "R8" : "R7", tag, "boot_done", int'(boot_done), int'(e_done));
      if (e_val) begin
         chk("R5", tag, "rx_data", int'(rx_data), e_dat);
         chk("R6", tag, "rx_index", int'(rx_index), e_idx);
      end
      // memory side: drive the bit of the current period, noise during header
      if (b >= 24) spi_miso = mem_byte((b - 24) / 8)[7 - ((b - 24) % 8)];
      else         spi_miso = e[0];
   endtask

   task automatic run_case(input int bc, input bit cp, input int s, input int ncyc,
                           input int bc_after, input string tag);
      rst_n = 1'b0; cpha_sel = cp; byte_count = CNT_W'(bc); seed = s; spi_miso = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", tag, "reset spi_cs_n", int'(spi_cs_n), 1);
      chk("R1", tag, "reset spi_sck", int'(spi_sck), 0);
      chk("R1", tag, "reset spi_mosi", int'(spi_mosi), 0);
      chk("R1", tag, "reset rx_valid", int'(rx_valid), 0);
      chk("R1", tag, "reset boot_done", int'(boot_done), 0);
      n_lat = (bc > MAXB) ? MAXB : bc;
      rst_n = 1'b1;
      for (int c = 1; c <= ncyc; c++) begin
         @(negedge clk);
         if (c == 1) byte_count = CNT_W'(bc_after);   // R2: must not matter
         model_cycle(c, cp, tag);
      end
   endtask

   initial begin
      run_case(3, 1'b0, 1, (24 + 24) * DIV + 25, 7, "phase0 three bytes");
      run_case(2, 1'b1, 2, (24 + 16) * DIV + 25, 0, "phase1 two bytes");
      run_case(0, 1'b0, 3, 40, 5, "zero count");
      run_case(7, 1'b1, 4, (24 + 48) * DIV + 25, 1, "R8 clamp");
      run_case(4, 1'b0, 5, 500, 4, "aborted read");
      run_case(4, 1'b0, 6, (24 + 32) * DIV + 25, 2, "R9 restart");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule